// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from memory to a byte stream. Software builds a circular ring of transmit descriptors in memory, programs the address of the ring's first descriptor and writes the control input with the DMA enable set. The block then finds the first descriptor that hardware owns and collects the buffer bytes of each owned descriptor into an internal staging store. When a descriptor marked as the end of a frame has been consumed, the collected bytes go out on the frame stream as one frame. Every consumed descriptor is written back to memory with its ownership bit cleared, which returns it to software. When the walk ends after at least one frame, the block raises a sticky transmit interrupt and clears its DMA start flag.

A descriptor is four 32-bit words at ascending byte addresses: status (+0), control and size (+4), buffer address (+8) and next-descriptor address (+12). The memory port is word-addressed through byte addresses that are multiples of four. Requests use a valid/ready handshake, and a request holds its valid, address, direction and write data until ready is seen. Only one read is outstanding at a time, and each read is answered by a single `mem_rsp_valid` pulse. Writes get no response. The frame stream is also valid/ready: once `tx_valid` is raised, it and `tx_data`/`tx_last` stay unchanged until `tx_ready` is high at a clock edge. Back-pressure on either port stalls the walk and loses nothing.

Top module: `txring_fetch`

## Requirements
- R1: A descriptor is used only when bit 31 of its status word (ownership) is set. Its buffer byte count is bits 10:0 of the control word, and bit 30 of the control word marks the end of a frame.
- R2: The walk begins at the programmed head address and skips descriptors that are not owned. It gives up with no memory write when the head is zero, or when an unowned descriptor's next pointer is zero or equals the head.
- R3: Buffer bytes are taken from word-aligned buffer addresses in ascending order, lowest byte lane first. Bytes from successive descriptors are appended in walk order.
- R4: After a descriptor's buffer has been gathered, its four words are written back at ascending addresses. The status word has bit 31 cleared and the other three words are unchanged.
- R5: When an end-of-frame descriptor has been written back, the gathered bytes leave as one frame with `tx_last` on the final byte, and the gathered count restarts at zero. An end-of-frame descriptor with nothing gathered sends no beat but still counts as a sent frame.
- R6: After a consumed descriptor, the walk follows its next pointer and continues while that descriptor is owned. It ends at an unowned descriptor or at a zero next pointer.
- R7: When the gathered count plus a descriptor's byte count would exceed STAGE_BYTES, the block writes only that descriptor's status word, with bit 14 set and ownership unchanged. It then ends the walk and sends no beat of the pending bytes. Exactly STAGE_BYTES bytes is allowed.
- R8: A walk that sent at least one frame sets `irq_tx` and clears `dma_start` in the cycle it ends. Otherwise both keep their values.
- R9: A control write (`ctl_we`) while idle loads `dma_start` from `ctl_dma_start` and starts a walk only when `ctl_dma_en` is set. A control write while busy has no effect.
- R10: `irq_ack` clears `irq_tx` in a cycle in which no walk ends.
- R11: A frame beat offered while `tx_ready` is low stays offered, with the same data and last flag, until it is taken.
- R12: At most one memory read is outstanding, and no request is made while a read is unanswered.
- R13: After reset the block is idle, `irq_tx` and `dma_start` are low, and no request or beat is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control write strobe |
| ctl_dma_en | input | 1 | Control write: start a walk |
| ctl_dma_start | input | 1 | Control write: value for the start flag |
| ctl_head | input | 32 | Control write: ring head address |
| irq_ack | input | 1 | Clears the transmit interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address, multiple of four |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Frame byte accepted |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| busy | output | 1 | A walk is in progress |
| dma_start | output | 1 | DMA start flag |
| irq_tx | output | 1 | Sticky transmit-complete interrupt |

## Verification
The bench builds the block with STAGE_BYTES set to 32 instead of the default 2048. Two small buffers can then overrun the staging store, and two 16-byte buffers fill it exactly, so both sides of the length-error boundary are exercised in a few hundred cycles. With the smaller store, frames that span several descriptors and uneven byte counts that end mid-word still fit in short runs. Those runs use pseudo-random stalls on both the memory port and the frame stream.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int LANES      = WORD_W / 8;
  localparam int OWN_BIT    = 31;
  localparam int EOF_BIT    = 30;
  localparam int LENERR_BIT = 14;
  localparam int SIZE_W     = 11;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DRD,
    S_DWAIT,
    S_EVAL,
    S_BRD,
    S_BWAIT,
    S_ERRWR,
    S_WB,
    S_EMIT,
    S_STEP,
    S_DONE
  } walk_st_t;
endpackage

// File: rtl/txr_stage_buf.sv
module txr_stage_buf #(
  parameter int DEPTH = 2048,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [IW-1:0]                 wr_pos,
  input  logic [txr_pkg::WORD_W-1:0]    wr_word,
  input  logic [2:0]                    wr_cnt,
  input  logic [IW-1:0]                 rd_pos,
  output logic [7:0]                    rd_byte
);
  import txr_pkg::*;

  logic [7:0]       store [DEPTH];
  logic [LANES-1:0] lane_en;

  // one enable per byte lane of the incoming word
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = wr_en && (3'(l) < wr_cnt);
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_en[l] && (int'(wr_pos) + l < DEPTH)) begin
        store[IW'(int'(wr_pos) + l)] <= wr_word[8*l +: 8];
      end
    end
  end

  assign rd_byte = store[rd_pos];
endmodule

// File: rtl/txr_emit.sv
module txr_emit #(
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [IW-1:0] go_len,
  output logic [IW-1:0] rd_pos,
  input  logic [7:0]    rd_byte,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [7:0]    o_data,
  output logic          o_last,
  output logic          done
);
  logic          active_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] len_q;

  assign rd_pos  = idx_q;
  assign o_valid = active_q;
  assign o_data  = rd_byte;
  assign o_last  = active_q && (idx_q == len_q - IW'(1));
  assign done    = active_q && o_ready && o_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      len_q    <= go_len;
    end else if (active_q && o_ready) begin
      if (o_last) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/txr_walk.sv
module txr_walk #(
  parameter int STAGE_BYTES = 2048,
  parameter int IW          = $clog2(STAGE_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_we,
  input  logic                       ctl_dma_en,
  input  logic                       ctl_dma_start,
  input  logic [txr_pkg::WORD_W-1:0] ctl_head,
  input  logic                       irq_ack,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic                       mem_req_we,
  output logic [txr_pkg::WORD_W-1:0] mem_req_addr,
  output logic [txr_pkg::WORD_W-1:0] mem_req_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [txr_pkg::WORD_W-1:0] mem_rsp_data,
  output logic                       stg_we,
  output logic [IW-1:0]              stg_pos,
  output logic [txr_pkg::WORD_W-1:0] stg_word,
  output logic [2:0]                 stg_cnt,
  output logic                       emit_go,
  output logic [IW-1:0]              emit_len,
  input  logic                       emit_done,
  output logic                       busy,
  output logic                       dma_start,
  output logic                       irq_tx
);
  import txr_pkg::*;

  localparam logic [WORD_W-1:0] OWN_MASK    = WORD_W'(1) << OWN_BIT;
  localparam logic [WORD_W-1:0] LENERR_MASK = WORD_W'(1) << LENERR_BIT;

  walk_st_t          st_q;
  logic [WORD_W-1:0] head_q;
  logic [WORD_W-1:0] cur_q;
  logic [WORD_W-1:0] dsc_q [DESC_WORDS];
  logic [1:0]        widx_q;
  logic              follow_q;
  logic [IW-1:0]     pkt_q;
  logic [SIZE_W-1:0] need_q;
  logic [WORD_W-1:0] boff_q;
  logic              sent_q;
  logic              start_q;
  logic              irq_q;

  logic              own_w;
  logic              eof_w;
  logic [SIZE_W-1:0] size_w;
  logic              fits_w;
  logic [WORD_W-1:0] nxt_w;
  logic [2:0]        take_w;

  assign own_w  = dsc_q[0][OWN_BIT];
  assign eof_w  = dsc_q[1][EOF_BIT];
  assign size_w = dsc_q[1][SIZE_W-1:0];
  assign nxt_w  = dsc_q[3];
  assign fits_w = (32'(pkt_q) + 32'(size_w)) <= 32'(STAGE_BYTES);
  assign take_w = (need_q >= SIZE_W'(LANES)) ? 3'(LANES) : 3'(need_q);

  assign busy      = (st_q != S_IDLE);
  assign dma_start = start_q;
  assign irq_tx    = irq_q;

  assign mem_req_valid = (st_q == S_DRD) || (st_q == S_BRD) ||
                         (st_q == S_ERRWR) || (st_q == S_WB);
  assign mem_req_we    = (st_q == S_ERRWR) || (st_q == S_WB);

  always_comb begin
    case (st_q)
      S_BRD:   mem_req_addr = dsc_q[2] + boff_q;
      S_ERRWR: mem_req_addr = cur_q;
      default: mem_req_addr = cur_q + {{(WORD_W-4){1'b0}}, widx_q, 2'b00};
    endcase
    if (st_q == S_ERRWR) begin
      mem_req_wdata = dsc_q[0] | LENERR_MASK;
    end else if (widx_q == 2'd0) begin
      mem_req_wdata = dsc_q[0] & ~OWN_MASK;
    end else begin
      mem_req_wdata = dsc_q[widx_q];
    end
  end

  assign stg_we   = (st_q == S_BWAIT) && mem_rsp_valid;
  assign stg_pos  = pkt_q;
  assign stg_word = mem_rsp_data;
  assign stg_cnt  = take_w;

  assign emit_go  = (st_q == S_WB) && mem_req_ready && (widx_q == 2'd3) &&
                    eof_w && (pkt_q != '0);
  assign emit_len = pkt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      head_q   <= '0;
      cur_q    <= '0;
      for (int i = 0; i < DESC_WORDS; i++) dsc_q[i] <= '0;
      widx_q   <= '0;
      follow_q <= 1'b0;
      pkt_q    <= '0;
      need_q   <= '0;
      boff_q   <= '0;
      sent_q   <= 1'b0;
      start_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (irq_ack) irq_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (ctl_we) begin
            start_q <= ctl_dma_start;
            if (ctl_dma_en) begin
              head_q   <= ctl_head;
              cur_q    <= ctl_head;
              widx_q   <= '0;
              follow_q <= 1'b0;
              pkt_q    <= '0;
              sent_q   <= 1'b0;
              st_q     <= (ctl_head == '0) ? S_DONE : S_DRD;
            end
          end
        end
        S_DRD: if (mem_req_ready) st_q <= S_DWAIT;
        S_DWAIT: begin
          if (mem_rsp_valid) begin
            dsc_q[widx_q] <= mem_rsp_data;
            if (widx_q == 2'd3) begin
              st_q <= S_EVAL;
            end else begin
              widx_q <= widx_q + 2'd1;
              st_q   <= S_DRD;
            end
          end
        end
        S_EVAL: begin
          widx_q <= '0;
          if (own_w) begin
            if (!fits_w) begin
              st_q <= S_ERRWR;
            end else begin
              need_q <= size_w;
              boff_q <= '0;
              st_q   <= (size_w == '0) ? S_WB : S_BRD;
            end
          end else if (follow_q || nxt_w == head_q || nxt_w == '0) begin
            st_q <= S_DONE;
          end else begin
            cur_q <= nxt_w;
            st_q  <= S_DRD;
          end
        end
        S_BRD: if (mem_req_ready) st_q <= S_BWAIT;
        S_BWAIT: begin
          if (mem_rsp_valid) begin
            pkt_q  <= pkt_q + IW'(take_w);
            need_q <= need_q - SIZE_W'(take_w);
            boff_q <= boff_q + WORD_W'(LANES);
            st_q   <= (need_q <= SIZE_W'(LANES)) ? S_WB : S_BRD;
          end
        end
        S_ERRWR: if (mem_req_ready) st_q <= S_DONE;
        S_WB: begin
          if (mem_req_ready) begin
            if (widx_q == 2'd3) begin
              if (eof_w && pkt_q != '0) begin
                st_q <= S_EMIT;
              end else begin
                if (eof_w) sent_q <= 1'b1;
                st_q <= S_STEP;
              end
            end else begin
              widx_q <= widx_q + 2'd1;
            end
          end
        end
        S_EMIT: begin
          if (emit_done) begin
            sent_q <= 1'b1;
            pkt_q  <= '0;
            st_q   <= S_STEP;
          end
        end
        S_STEP: begin
          widx_q <= '0;
          if (nxt_w == '0) begin
            st_q <= S_DONE;
          end else begin
            cur_q    <= nxt_w;
            follow_q <= 1'b1;
            st_q     <= S_DRD;
          end
        end
        S_DONE: begin
          if (sent_q) begin
            irq_q   <= 1'b1;
            start_q <= 1'b0;
          end
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch #(
  parameter int STAGE_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic        ctl_dma_en,
  input  logic        ctl_dma_start,
  input  logic [31:0] ctl_head,
  input  logic        irq_ack,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        busy,
  output logic        dma_start,
  output logic        irq_tx
);
  localparam int IW = $clog2(STAGE_BYTES + 1);

  logic          stg_we;
  logic [IW-1:0] stg_pos;
  logic [31:0]   stg_word;
  logic [2:0]    stg_cnt;
  logic [IW-1:0] rd_pos;
  logic [7:0]    rd_byte;
  logic          emit_go;
  logic [IW-1:0] emit_len;
  logic          emit_done;

  txr_walk #(.STAGE_BYTES(STAGE_BYTES), .IW(IW)) i_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_we        (ctl_we),
    .ctl_dma_en    (ctl_dma_en),
    .ctl_dma_start (ctl_dma_start),
    .ctl_head      (ctl_head),
    .irq_ack       (irq_ack),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .stg_we        (stg_we),
    .stg_pos       (stg_pos),
    .stg_word      (stg_word),
    .stg_cnt       (stg_cnt),
    .emit_go       (emit_go),
    .emit_len      (emit_len),
    .emit_done     (emit_done),
    .busy          (busy),
    .dma_start     (dma_start),
    .irq_tx        (irq_tx)
  );

  txr_stage_buf #(.DEPTH(STAGE_BYTES), .IW(IW)) i_stage (
    .clk     (clk),
    .wr_en   (stg_we),
    .wr_pos  (stg_pos),
    .wr_word (stg_word),
    .wr_cnt  (stg_cnt),
    .rd_pos  (rd_pos),
    .rd_byte (rd_byte)
  );

  txr_emit #(.IW(IW)) i_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (emit_go),
    .go_len  (emit_len),
    .rd_pos  (rd_pos),
    .rd_byte (rd_byte),
    .o_valid (tx_valid),
    .o_ready (tx_ready),
    .o_data  (tx_data),
    .o_last  (tx_last),
    .done    (emit_done)
  );
endmodule

// File: rtl/txring_fetch_chk.sv
module txring_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        mem_rsp_valid,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        busy,
  input logic        dma_start,
  input logic        irq_tx
);
  logic rd_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_open <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) rd_open <= 1'b1;
    else if (mem_rsp_valid) rd_open <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)); // R12
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_req_valid); // R12
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R11
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $fell(busy)); // R8
  AST_START_CLR_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> !dma_start); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !mem_req_valid); // R9
endmodule

bind txring_fetch txring_fetch_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .tx_last       (tx_last),
  .busy          (busy),
  .dma_start     (dma_start),
  .irq_tx        (irq_tx)
);

// File: tb/test_txring_fetch.sv
module test_txring_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int STAGE      = 32;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, ctl_dma_en = 1'b0, ctl_dma_start = 1'b0;
  logic [31:0] ctl_head = '0;
  logic        irq_ack = 1'b0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        busy, dma_start, irq_tx;

  txring_fetch #(.STAGE_BYTES(STAGE)) i_txring_fetch (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem     [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  logic [31:0] exp_wa[$], exp_wd[$];
  logic [8:0]  exp_b[$];
  int   ntot = 0, nfail = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit   bp = 1'b0, idle_cmp = 1'b0;
  bit   m_irq = 1'b0, m_start = 1'b0, m_sent = 1'b0;
  bit   p_acc = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr, p_wdata;
  bit   hold_v = 1'b0, hold_l;
  logic [7:0] hold_d;

  function automatic logic [31:0] rdm(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction
  function automatic logic [31:0] rdr(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'd0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      ntot++; nfail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
      summary();
      $finish;
    end
    mem_rsp_valid = 1'b0;
    if (p_acc) begin
      if (p_we) mem[p_addr] = p_wdata;
      else begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rdm(p_addr);
        chk(!mem_req_valid, "R12", "request while read open", 32'(mem_req_valid), 0);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready = bp ? lfsr[0] : 1'b1;
    tx_ready      = bp ? lfsr[5] : 1'b1;
    #1;
    p_acc = mem_req_valid && mem_req_ready;
    p_we = mem_req_we; p_addr = mem_req_addr; p_wdata = mem_req_wdata;
    if (p_acc && p_we) begin
      if (exp_wa.size() == 0) chk(0, "R4", "unexpected write", mem_req_addr, 0);
      else begin
        logic [31:0] ea, ed;
        ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
        chk(mem_req_addr == ea, ed[14] ? "R7" : "R4", "write address", mem_req_addr, ea);
        chk(mem_req_wdata == ed, ed[14] ? "R7" : "R4", "write data", mem_req_wdata, ed);
      end
    end
    if (hold_v) chk(tx_valid && tx_data == hold_d && tx_last == hold_l, "R11", "held beat",
                    {tx_valid, tx_last, tx_data}, {1'b1, hold_l, hold_d});
    hold_v = tx_valid && !tx_ready; hold_d = tx_data; hold_l = tx_last;
    if (tx_valid && tx_ready) begin
      if (exp_b.size() == 0) chk(0, "R5", "unexpected beat", tx_data, 0);
      else begin
        logic [8:0] eb;
        eb = exp_b.pop_front();
        chk({tx_last, tx_data} == eb, "R3", "frame byte/last", {tx_last, tx_data}, eb);
      end
    end
    if (idle_cmp) begin
      chk(irq_tx == m_irq, "R8", "irq_tx", irq_tx, m_irq);
      chk(dma_start == m_start, "R8", "dma_start", dma_start, m_start);
    end
  endtask

  task automatic model_walk(logic [31:0] head);
    logic [31:0] a, st, ct, bf, nx;
    int sz;
    bit found;
    logic [7:0] stage[$];
    ref_mem = mem;
    m_sent = 0;
    a = head; found = 0;
    while (a != 0) begin
      st = rdr(a); nx = rdr(a + 12);
      if (st[31]) begin found = 1; break; end
      if (nx == head || nx == 0) break;
      a = nx;
    end
    if (!found) a = 0;
    while (a != 0) begin
      st = rdr(a); ct = rdr(a + 4); bf = rdr(a + 8); nx = rdr(a + 12);
      sz = int'(ct & 32'h7ff);
      if (stage.size() + sz > STAGE) begin
        exp_wa.push_back(a); exp_wd.push_back(st | 32'h4000);
        break;
      end
      for (int i = 0; i < sz; i++) stage.push_back(8'(rdr(bf + 32'((i / 4) * 4)) >> (8 * (i % 4))));
      exp_wa.push_back(a);      exp_wd.push_back(st & 32'h7fffffff);
      exp_wa.push_back(a + 4);  exp_wd.push_back(ct);
      exp_wa.push_back(a + 8);  exp_wd.push_back(bf);
      exp_wa.push_back(a + 12); exp_wd.push_back(nx);
      ref_mem[a] = st & 32'h7fffffff;
      if (ct[30]) begin
        for (int i = 0; i < stage.size(); i++) exp_b.push_back({i == stage.size() - 1, stage[i]});
        stage.delete();
        m_sent = 1;
      end
      if (nx == 0) a = 0;
      else begin
        st = rdr(nx);
        a = st[31] ? nx : 32'd0;
      end
    end
  endtask

  task automatic mk_desc(logic [31:0] a, bit own, int sz, bit eof, logic [31:0] bf, logic [31:0] nx);
    mem[a]      = {own, 31'h00000123};
    mem[a + 4]  = {1'b0, eof, 19'h0, 11'(sz)};
    mem[a + 8]  = bf;
    mem[a + 12] = nx;
    for (int w = 0; w < 8; w++) mem[bf + 32'(4 * w)] = {bf[15:0] ^ 16'h5a5a, 8'(w * 37), 8'(w + 1)};
  endtask

  task automatic run_walk(logic [31:0] head, bit en, bit st, bit late_kick, string tag);
    int n;
    exp_wa.delete(); exp_wd.delete(); exp_b.delete();
    m_sent = 0;
    if (en) model_walk(head);
    idle_cmp = 0;
    ctl_we = 1; ctl_dma_en = en; ctl_dma_start = st; ctl_head = head;
    tick();
    ctl_we = 0;
    m_start = st;
    n = 0;
    while (busy) begin
      if (late_kick && n == 3) begin
        ctl_we = 1; ctl_dma_en = 1; ctl_dma_start = 1; ctl_head = head;
      end else ctl_we = 0;
      tick();
      n++;
    end
    ctl_we = 0;
    if (m_sent) begin m_irq = 1; m_start = 0; end
    tick();
    idle_cmp = 1;
    tick();
    chk(exp_wa.size() == 0, tag, "missing writes", exp_wa.size(), 0);
    chk(exp_b.size() == 0, tag, "missing beats", exp_b.size(), 0);
  endtask

  task automatic ack_irq();
    irq_ack = 1; m_irq = 0;
    tick();
    irq_ack = 0;
    tick();
    chk(irq_tx == 0, "R10", "irq after ack", irq_tx, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R13 reset state
    chk(!busy && !tx_valid && !mem_req_valid, "R13", "idle after reset",
        {busy, tx_valid, mem_req_valid}, 0);
    chk(!irq_tx && !dma_start, "R13", "flags after reset", {irq_tx, dma_start}, 0);
    idle_cmp = 1;

    // R1 R5 single-descriptor frame, unowned rest of ring
    mk_desc(32'h100, 1, 10, 1, 32'h1000, 32'h110);
    mk_desc(32'h110, 0, 8, 1, 32'h1100, 32'h120);
    mk_desc(32'h120, 0, 8, 1, 32'h1200, 32'h100);
    run_walk(32'h100, 1, 1, 0, "R5");
    ack_irq();

    // R3 R6 multi-descriptor frames with stalls
    bp = 1;
    mk_desc(32'h200, 1, 5, 0, 32'h2000, 32'h210);
    mk_desc(32'h210, 1, 7, 0, 32'h2100, 32'h220);
    mk_desc(32'h220, 1, 4, 1, 32'h2200, 32'h230);
    mk_desc(32'h230, 1, 3, 1, 32'h2300, 32'h240);
    mk_desc(32'h240, 0, 6, 1, 32'h2400, 32'h200);
    run_walk(32'h200, 1, 1, 0, "R6");
    ack_irq();

    // R2 skip unowned from head; zero next ends the walk (R6)
    mk_desc(32'h300, 0, 4, 1, 32'h3000, 32'h310);
    mk_desc(32'h310, 0, 4, 1, 32'h3100, 32'h320);
    mk_desc(32'h320, 1, 9, 1, 32'h3200, 32'h0);
    run_walk(32'h300, 1, 0, 0, "R2");
    ack_irq();

    // R2 nothing owned: walk ends at next==head, no write, flags kept
    mk_desc(32'h400, 0, 4, 1, 32'h4000, 32'h410);
    mk_desc(32'h410, 0, 4, 1, 32'h4100, 32'h400);
    run_walk(32'h400, 1, 1, 0, "R2");

    // R7 overflow, plus R9 control write while busy ignored
    mk_desc(32'h500, 1, 20, 0, 32'h5000, 32'h510);
    mk_desc(32'h510, 1, 20, 1, 32'h5100, 32'h500);
    run_walk(32'h500, 1, 0, 1, "R7");
    chk(rdm(32'h510) == 32'h80004123, "R7", "error status in memory", rdm(32'h510), 32'h80004123);
    chk(rdm(32'h500) == 32'h00000123, "R4", "first status returned", rdm(32'h500), 32'h00000123);

    // R7 exact fit is allowed
    mk_desc(32'h600, 1, 16, 0, 32'h6000, 32'h610);
    mk_desc(32'h610, 1, 16, 1, 32'h6100, 32'h600);
    run_walk(32'h600, 1, 1, 0, "R7");
    ack_irq();

    // R5 zero-length end-of-frame descriptor: no beat, still counts
    bp = 0;
    mk_desc(32'h700, 1, 0, 1, 32'h7000, 32'h710);
    mk_desc(32'h710, 0, 4, 1, 32'h7100, 32'h700);
    run_walk(32'h700, 1, 1, 0, "R5");
    ack_irq();

    // R9 control write without enable: flag loads, no walk
    run_walk(32'h600, 0, 1, 0, "R9");
    chk(!busy, "R9", "no walk without enable", busy, 0);
    // R2 zero head: nothing fetched, flag loaded from the write
    run_walk(32'h0, 1, 0, 0, "R2");
    chk(dma_start == 0, "R9", "flag from second write", dma_start, 0);

    summary();
    $finish;
  end
endmodule